// File: doc/BRIEF.md
# Cascadable Adder/Subtracter Slice

This block is a combinational arithmetic slice of parameterized width. A mode input chooses between addition and subtraction of two operand words. It returns one result word and three flags. The result word is the same whether the operands are read as unsigned or as two's-complement values. Only the flag that marks an out-of-range result differs: the carry flag serves unsigned use, and the signed overflow flag serves two's-complement use.

In subtract mode, the carry input and carry output are active-low borrows. A wide operation can therefore be built from narrow slices: each slice's carry output feeds the next slice's carry input, and the chain behaves the same way in both modes. A fourth output combines the carry output with the mode. It gives an unsigned overflow indication that is high-active in either mode.

The slice has no clock, no reset and no storage. The intended widths are 4, 8 and 16 bits.

Top module: `addsub_slice`

## Requirements
- R1: With `add_mode` = 1, `result` equals (`opnd_a` + `opnd_b` + `carry_in`) modulo 2^N, and `carry_out` is 1 exactly when that sum is 2^N or more.
- R2: With `add_mode` = 0, `result` equals (`opnd_a` − `opnd_b` − 1 + `carry_in`) modulo 2^N. Here `carry_in` = 0 requests one extra borrow, and `carry_in` = 1 requests none.
- R3: With `add_mode` = 0, `carry_out` is 0 (a borrow out) exactly when the unsigned value `opnd_a` − `opnd_b` − (1 − `carry_in`) is below zero. Otherwise `carry_out` is 1.
- R4: In both modes, `sgn_ovf` is 1 exactly when the operation on the two's-complement operands gives a value outside −2^(N−1) .. 2^(N−1)−1.
- R5: `uns_ovf` equals `carry_out` XNOR `add_mode`. It is 1 when an unsigned sum exceeds 2^N−1 or an unsigned difference falls below zero.
- R6: Two N-bit slices, with the lower slice's `carry_out` wired to the upper slice's `carry_in`, give the same result word, `carry_out` and `sgn_ovf` as one 2N-bit slice, in both modes.
- R7: All outputs are a function of the present inputs only. With all inputs at 0 in add mode, the slice returns `result` = 0 and all three flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | N | Minuend or first addend |
| opnd_b | input | N | Subtrahend or second addend |
| carry_in | input | 1 | Carry in (add mode), active-low borrow in (subtract mode) |
| add_mode | input | 1 | 1 selects addition, 0 selects subtraction |
| result | output | N | Sum or difference |
| carry_out | output | 1 | Carry out (add mode), active-low borrow out (subtract mode) |
| sgn_ovf | output | 1 | Two's-complement overflow, high-active |
| uns_ovf | output | 1 | Unsigned overflow, high-active in both modes |

## Verification
The bench builds the slice at N = 4, 8 and 16. It also builds a pair of 4-bit slices chained into an extra 8-bit reference slice. At N = 4 the full input space of 1024 combinations can be swept, so every carry, borrow and overflow corner is reached. The 8- and 16-bit instances get random vectors plus the edge operands 0, all-ones and the signed limits. These show that the carry and overflow taps track the parameter. The chained pair exercises the polarity flip of the borrow between slices in both modes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  function automatic logic bit_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic bit_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

  function automatic logic uns_flag(input logic cy, input logic add);
    return ~(cy ^ add);
  endfunction

endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int N = 4
) (
  input  logic [N-1:0] b_in,
  input  logic         add_mode,
  output logic [N-1:0] b_eff
);
  always_comb b_eff = add_mode ? b_in : ~b_in;
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         c_in,
  output logic [N-1:0] sum,
  output logic [N:0]   carry
);
  import addsub_pkg::*;

  assign carry[0] = c_in;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum[i]     = bit_sum(x[i], y[i], carry[i]);
    assign carry[i+1] = bit_carry(x[i], y[i], carry[i]);
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int N = 4
) (
  input  logic [N:0] carry,
  input  logic       add_mode,
  output logic       cy_out,
  output logic       s_ovf,
  output logic       u_ovf
);
  import addsub_pkg::*;

  logic carry_into_msb;
  logic carry_out_msb;

  assign carry_into_msb = carry[N-1];
  assign carry_out_msb  = carry[N];
  assign cy_out         = carry_out_msb;
  assign s_ovf          = carry_into_msb ^ carry_out_msb;
  assign u_ovf          = uns_flag(carry_out_msb, add_mode);
endmodule

// File: rtl/addsub_slice.sv
module addsub_slice #(
  parameter int N = 4
) (
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  input  logic         carry_in,
  input  logic         add_mode,
  output logic [N-1:0] result,
  output logic         carry_out,
  output logic         sgn_ovf,
  output logic         uns_ovf
);
  localparam int WU = N + 1;
  localparam int WS = N + 2;

  logic [N-1:0] b_eff;
  logic [N:0]   chain;

  addsub_operand #(.N(N)) u_operand (
    .b_in     (opnd_b),
    .add_mode (add_mode),
    .b_eff    (b_eff)
  );

  addsub_ripple #(.N(N)) u_ripple (
    .x     (opnd_a),
    .y     (b_eff),
    .c_in  (carry_in),
    .sum   (result),
    .carry (chain)
  );

  addsub_flags #(.N(N)) u_flags (
    .carry    (chain),
    .add_mode (add_mode),
    .cy_out   (carry_out),
    .s_ovf    (sgn_ovf),
    .u_ovf    (uns_ovf)
  );

  // Wide views of the operation, used only by the checks below
  logic [WU-1:0] wide_add;
  logic [WU-1:0] wide_lhs;
  logic [WU-1:0] wide_rhs;
  logic [WS-1:0] sx_a;
  logic [WS-1:0] sx_b;
  logic [WS-1:0] wide_signed;

  always_comb begin
    wide_add    = {1'b0, opnd_a} + {1'b0, opnd_b} + {{N{1'b0}}, carry_in};
    wide_lhs    = {1'b0, opnd_a};
    wide_rhs    = {1'b0, opnd_b} + {{N{1'b0}}, ~carry_in};
    sx_a        = {{2{opnd_a[N-1]}}, opnd_a};
    sx_b        = {{2{opnd_b[N-1]}}, opnd_b};
    wide_signed = add_mode ? (sx_a + sx_b + {{(WS-1){1'b0}}, carry_in})
                           : (sx_a - sx_b - {{(WS-1){1'b0}}, ~carry_in});
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, carry_in, add_mode})) begin
      if (add_mode)
        assert_add_sum_R1: assert ({carry_out, result} == wide_add)
          else $error("R1 sum or carry mismatch");
      if (!add_mode)
        assert_sub_diff_R2: assert (result == (opnd_a - opnd_b - {{(N-1){1'b0}}, ~carry_in}))
          else $error("R2 difference mismatch");
      if (!add_mode)
        assert_borrow_R3: assert (carry_out == (wide_lhs >= wide_rhs))
          else $error("R3 borrow mismatch");
      assert_sgn_ovf_R4: assert (sgn_ovf ==
                                 !(wide_signed[WS-1] == wide_signed[WS-2] &&
                                   wide_signed[WS-2] == wide_signed[N-1]))
        else $error("R4 signed overflow mismatch");
      assert_uns_ovf_R5: assert (uns_ovf == (add_mode ? carry_out : !carry_out))
        else $error("R5 unsigned overflow mismatch");
    end
  end
endmodule

// File: tb/addsub_slice_bench.sv
module addsub_slice_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // 4-bit instance
  logic [3:0] a4, b4, s4;
  logic ci4, add4, co4, of4, uo4;
  addsub_slice #(.N(4)) u_addsub_slice (
    .opnd_a(a4), .opnd_b(b4), .carry_in(ci4), .add_mode(add4),
    .result(s4), .carry_out(co4), .sgn_ovf(of4), .uns_ovf(uo4));

  // 8-bit instance
  logic [7:0] a8, b8, s8;
  logic ci8, add8, co8, of8, uo8;
  addsub_slice #(.N(8)) u_addsub_slice8 (
    .opnd_a(a8), .opnd_b(b8), .carry_in(ci8), .add_mode(add8),
    .result(s8), .carry_out(co8), .sgn_ovf(of8), .uns_ovf(uo8));

  // 16-bit instance
  logic [15:0] a16, b16, s16;
  logic ci16, add16, co16, of16, uo16;
  addsub_slice #(.N(16)) u_addsub_slice16 (
    .opnd_a(a16), .opnd_b(b16), .carry_in(ci16), .add_mode(add16),
    .result(s16), .carry_out(co16), .sgn_ovf(of16), .uns_ovf(uo16));

  // cascade: two 4-bit slices against one 8-bit slice
  logic [7:0] ca, cb, cw_s;
  logic cci, cadd, cw_co, cw_of, cw_uo;
  logic [3:0] lo_s, hi_s;
  logic lo_co, lo_of, lo_uo, hi_co, hi_of, hi_uo;
  addsub_slice #(.N(4)) u_lo (
    .opnd_a(ca[3:0]), .opnd_b(cb[3:0]), .carry_in(cci), .add_mode(cadd),
    .result(lo_s), .carry_out(lo_co), .sgn_ovf(lo_of), .uns_ovf(lo_uo));
  addsub_slice #(.N(4)) u_hi (
    .opnd_a(ca[7:4]), .opnd_b(cb[7:4]), .carry_in(lo_co), .add_mode(cadd),
    .result(hi_s), .carry_out(hi_co), .sgn_ovf(hi_of), .uns_ovf(hi_uo));
  addsub_slice #(.N(8)) u_wide (
    .opnd_a(ca), .opnd_b(cb), .carry_in(cci), .add_mode(cadd),
    .result(cw_s), .carry_out(cw_co), .sgn_ovf(cw_of), .uns_ovf(cw_uo));

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // behavioural reference from the requirements, integer arithmetic
  task automatic model(input int n, input int a, input int b, input bit ci, input bit add,
                       output int s, output bit co, output bit ofl, output bit uofl);
    int m = 1 << n;
    int half = 1 << (n - 1);
    int sa = (a >= half) ? a - m : a;
    int sb = (b >= half) ? b - m : b;
    int d;
    int sr;
    if (add) begin
      d  = a + b + int'(ci);
      co = (d >= m);
      sr = sa + sb + int'(ci);
    end else begin
      d  = a - b - (ci ? 0 : 1);
      co = (d >= 0);
      sr = sa - sb - (ci ? 0 : 1);
    end
    s    = (d + m) % m;
    ofl  = (sr >= half) || (sr < -half);
    uofl = add ? co : !co;
  endtask

  task automatic check_slice(input int n, input int a, input int b, input bit ci, input bit add,
                             input int gs, input bit gco, input bit gof, input bit guo);
    int s; bit co, ofl, uofl;
    model(n, a, b, ci, add, s, co, ofl, uofl);
    if (add) begin
      chk("R1 sum", gs, s);
      chk("R1 carry", int'(gco), int'(co));
    end else begin
      chk("R2 difference", gs, s);
      chk("R3 borrow", int'(gco), int'(co));
    end
    chk("R4 signed overflow", int'(gof), int'(ofl));
    chk("R5 unsigned overflow", int'(guo), int'(uofl));
  endtask

  task automatic drive_wide(input int a8v, input int b8v, input int a16v, input int b16v,
                            input bit ci, input bit add);
    a8 = a8v[7:0]; b8 = b8v[7:0]; ci8 = ci; add8 = add;
    a16 = a16v[15:0]; b16 = b16v[15:0]; ci16 = !ci; add16 = !add;
  endtask

  task automatic check_wide();
    check_slice(8, int'(a8), int'(b8), ci8, add8, int'(s8), co8, of8, uo8);
    check_slice(16, int'(a16), int'(b16), ci16, add16, int'(s16), co16, of16, uo16);
  endtask

  task automatic cascade(input int a, input int b, input bit ci, input bit add);
    @(negedge clk);
    ca = a[7:0]; cb = b[7:0]; cci = ci; cadd = add;
    #5;
    chk("R6 cascade result", int'({hi_s, lo_s}), int'(cw_s));
    chk("R6 cascade carry", int'(hi_co), int'(cw_co));
    chk("R6 cascade overflow", int'(hi_of), int'(cw_of));
    check_slice(8, a, b, ci, add, int'({hi_s, lo_s}), hi_co, hi_of, hi_uo);
  endtask

  initial begin
    a4 = '0; b4 = '0; ci4 = 1'b0; add4 = 1'b1;
    a8 = '0; b8 = '0; ci8 = 1'b0; add8 = 1'b1;
    a16 = '0; b16 = '0; ci16 = 1'b0; add16 = 1'b1;
    ca = '0; cb = '0; cci = 1'b0; cadd = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    // R7: idle state with all-zero inputs in add mode
    chk("R7 idle result", int'(s4), 0);
    chk("R7 idle carry", int'(co4), 0);
    chk("R7 idle signed overflow", int'(of4), 0);
    chk("R7 idle unsigned overflow", int'(uo4), 0);

    // exhaustive 4-bit sweep (R1..R5), random wide slices alongside
    for (int md = 0; md < 2; md++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            a4 = a[3:0]; b4 = b[3:0]; ci4 = c[0]; add4 = md[0];
            drive_wide(int'($urandom), int'($urandom), int'($urandom), int'($urandom),
                       c[0], md[0]);
            #5;
            check_slice(4, a, b, c[0], md[0], int'(s4), co4, of4, uo4);
            check_wide();
          end

    // R7: same inputs again give the same outputs
    @(negedge clk);
    a4 = 4'd9; b4 = 4'd12; ci4 = 1'b1; add4 = 1'b0;
    #5;
    chk("R7 repeat result", int'(s4), 13);
    @(negedge clk);
    #5;
    chk("R7 repeat result stable", int'(s4), 13);

    // edge operands at 8 and 16 bits
    for (int k = 0; k < 16; k++) begin
      int e8[4]  = '{0, 255, 127, 128};
      int e16[4] = '{0, 65535, 32767, 32768};
      for (int m = 0; m < 4; m++) begin
        @(negedge clk);
        drive_wide(e8[k % 4], e8[m], e16[k % 4], e16[m], k[2], k[3]);
        #5;
        check_wide();
      end
    end

    // R6 cascade: corners then random, both modes
    for (int md = 0; md < 2; md++)
      for (int c = 0; c < 2; c++) begin
        cascade(255, 1, c[0], md[0]);
        cascade(0, 1, c[0], md[0]);
        cascade(127, 128, c[0], md[0]);
        cascade(128, 127, c[0], md[0]);
        cascade(15, 0, c[0], md[0]);
      end
    for (int i = 0; i < 400; i++)
      cascade(int'($urandom & 255), int'($urandom & 255), $urandom % 2 == 1, $urandom % 2 == 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule